// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the column address for each beat of one SDRAM burst. A controller pulses `load` with the start column, a burst-length code and an order bit. The next cycle the block presents the first column with `valid` high. Each `advance` pulse moves it to the next beat. `last` marks the final beat of a fixed-length burst, and an advance on that beat ends the burst.

Fixed bursts of 1, 2, 4 and 8 beats stay inside the aligned block of that size that holds the start column. In sequential order the low bits count upward and wrap. In interleave order beat n is the start column with its low bits XORed by n. Full-page bursts always count sequentially over the whole column range and wrap from the top column to column 0. They run until `stop` is pulsed. A new `load` during a burst restarts the sequence, which is how an interrupting read or write command is modelled.

Top module: `sdram_burst_colgen`

## Requirements
- R1: After reset, and whenever no burst is active, `valid` and `last` are 0 and `col` is 0.
- R2: A `load` with a legal code makes `valid` 1 on the next cycle, with `col` equal to the `start_col` that was loaded.
- R3: With `ilv`=0 and `bl_code` 1, 2 or 3 (burst of 2, 4 or 8 = 2^code), each advance sets the low code bits of `col` to (start + n) mod burst length, where n is the beat number.
- R4: With `ilv`=1 and `bl_code` 1, 2 or 3, beat n presents `start_col` with its low code bits XORed by n.
- R5: With `bl_code`=0 (a single beat), the start column is shown once with `last`=1, and an advance ends the burst.
- R6: In a fixed-length burst, the column bits above the burst field stay equal to those of `start_col` on every beat.
- R7: With `bl_code`=7 (full page), beat n is (start + n) mod 2^COL_W whatever the value of `ilv`, and `last` stays 0.
- R8: `stop` during an active burst with no `load` ends it: `valid` is 0 on the next cycle.
- R9: A `load` during an active burst restarts from the new start column, length and order on the next cycle. `load` takes priority over `stop` and `advance`.
- R10: A `load` with a reserved `bl_code` (4, 5 or 6) is ignored, and the state it could have changed (`valid`, `col`) stays as it was.
- R11: While a burst is active and none of `load`, `stop` or `advance` is asserted, `col`, `valid` and `last` hold their values.
- R12: An `advance` on a beat with `last`=1 ends the burst: `valid` is 0 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| load | input | 1 | Start a burst at `start_col` |
| advance | input | 1 | Step to the next beat |
| stop | input | 1 | Terminate the active burst |
| start_col | input | COL_W | Start column of the burst |
| bl_code | input | 3 | Burst length: 0..3 = 2^code beats, 7 = full page, 4..6 reserved |
| ilv | input | 1 | 1 = interleave order, 0 = sequential order |
| col | output | COL_W | Column address of the current beat |
| valid | output | 1 | A burst beat is being presented |
| last | output | 1 | Current beat is the final beat of a fixed burst |

## Verification
The assertions assume that `bl_code`, `ilv` and `start_col` matter only in a cycle where `load` is high. They also assume that `advance` and `stop` have meaning only while `valid` is high. A pulse of either while idle must leave the block idle. The stimulus drives every control signal half a cycle away from the sampling edge. It changes the code and the order bit only together with `load`, and it also sends stray advances while idle and reserved codes, so that the cases where an input has no effect are covered. Every cycle the outputs are compared with a behavioural model that works out the expected column using integer division and modulo arithmetic.

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen #(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             advance,
  input  logic             stop,
  input  logic [COL_W-1:0] start_col,
  input  logic [2:0]       bl_code,
  input  logic             ilv,
  output logic [COL_W-1:0] col,
  output logic             valid,
  output logic             last
);

  localparam logic [2:0] CODE_FULL = 3'd7;

  logic             busy;
  logic [COL_W-1:0] base;
  logic [COL_W-1:0] beat;
  logic [1:0]       lg;
  logic             full_q;
  logic             ilv_q;

  logic             code_fixed;
  logic             code_ok;
  logic [COL_W-1:0] mask;
  logic [COL_W-1:0] seq_col;
  logic [COL_W-1:0] ilv_col;
  logic [COL_W-1:0] full_col;
  logic             at_end;

  assign code_fixed = (bl_code[2] == 1'b0);
  assign code_ok    = code_fixed || (bl_code == CODE_FULL);

  assign mask     = (COL_W'(1) << lg) - COL_W'(1);
  assign full_col = base + beat;
  assign seq_col  = (base & ~mask) | (full_col & mask);
  assign ilv_col  = base ^ (beat & mask);
  assign at_end   = !full_q && (beat == mask);

  always_comb begin
    if (!busy)       col = '0;
    else if (full_q) col = full_col;
    else if (ilv_q)  col = ilv_col;
    else             col = seq_col;
  end

  assign valid = busy;
  assign last  = busy && at_end;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      base   <= '0;
      beat   <= '0;
      lg     <= '0;
      full_q <= 1'b0;
      ilv_q  <= 1'b0;
    end else if (load) begin
      if (code_ok) begin
        busy   <= 1'b1;
        base   <= start_col;
        beat   <= '0;
        lg     <= code_fixed ? bl_code[1:0] : 2'd0;
        full_q <= !code_fixed;
        ilv_q  <= ilv && code_fixed;
      end
    end else if (busy && stop) begin
      busy <= 1'b0;
    end else if (busy && advance) begin
      if (at_end) busy <= 1'b0;
      else        beat <= beat + COL_W'(1);
    end
  end

endmodule

// File: rtl/sdram_burst_colgen_chk.sv
module sdram_burst_colgen_chk #(
  parameter int COL_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             load,
  input logic             advance,
  input logic             stop,
  input logic [COL_W-1:0] start_col,
  input logic [2:0]       bl_code,
  input logic             ilv,
  input logic [COL_W-1:0] col,
  input logic             valid,
  input logic             last
);

  logic legal;
  assign legal = (bl_code < 3'd4) || (bl_code == 3'd7);

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> (col == '0) && !last); // R1

  AST_LOAD_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    load && legal |=> valid && (col == $past(start_col))); // R2

  AST_SINGLE_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    load && (bl_code == 3'd0) |=> last); // R5

  AST_FULL_NO_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    load && (bl_code == 3'd7) |=> !last); // R7

  AST_STOP_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    valid && stop && !load |=> !valid); // R8

  AST_RESERVED_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    load && !legal |=> $stable(valid) && $stable(col)); // R10

  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    valid && !load && !stop && !advance |=> valid && $stable(col) && $stable(last)); // R11

  AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    last && advance && !load && !stop |=> !valid); // R12

endmodule

bind sdram_burst_colgen sdram_burst_colgen_chk #(.COL_W(COL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .load(load), .advance(advance), .stop(stop),
  .start_col(start_col), .bl_code(bl_code), .ilv(ilv),
  .col(col), .valid(valid), .last(last)
);

// File: tb/test_sdram_burst_colgen.sv
module test_sdram_burst_colgen;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       load = 1'b0;
  logic       advance = 1'b0;
  logic       stop = 1'b0;
  logic [7:0] start_col = '0;
  logic [2:0] bl_code = '0;
  logic       ilv = 1'b0;
  logic [7:0] col;
  logic       valid;
  logic       last;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  string tag = "R1";

  int m_valid = 0, m_base = 0, m_beat = 0, m_len = 1, m_full = 0, m_ilv = 0;

  always #4 clk = ~clk;

  sdram_burst_colgen i_sdram_burst_colgen (
    .clk(clk), .rst_n(rst_n), .load(load), .advance(advance), .stop(stop),
    .start_col(start_col), .bl_code(bl_code), .ilv(ilv),
    .col(col), .valid(valid), .last(last)
  );

  function automatic int exp_col();
    if (m_valid == 0) return 0;
    if (m_full != 0) return (m_base + m_beat) % 256;
    if (m_ilv != 0) return m_base ^ m_beat;
    return (m_base / m_len) * m_len + ((m_base % m_len) + m_beat) % m_len;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_valid = 0; m_beat = 0;
    end else if (load) begin
      if (bl_code < 4 || bl_code == 7) begin
        m_valid = 1; m_base = int'(start_col); m_beat = 0;
        m_full = (bl_code == 7) ? 1 : 0;
        m_len = (bl_code == 7) ? 256 : (1 << bl_code);
        m_ilv = (bl_code == 7) ? 0 : int'(ilv);
      end
    end else if (m_valid != 0 && stop) begin
      m_valid = 0;
    end else if (m_valid != 0 && advance) begin
      if (m_full == 0 && m_beat == m_len - 1) m_valid = 0;
      else m_beat = (m_beat + 1) % 256;
    end
  end

  always @(negedge clk) begin
    int e_last;
    cycles++;
    e_last = (m_valid != 0 && m_full == 0 && m_beat == m_len - 1) ? 1 : 0;
    checks++;
    if (int'(col) != exp_col() || int'(valid) != m_valid || int'(last) != e_last) begin
      fails++;
      $display("FAIL %s: col=%h valid=%0d last=%0d expected col=%h valid=%0d last=%0d",
               tag, col, valid, last, exp_col(), m_valid, e_last);
    end
    if (cycles > 20000) begin
      fails++;
      $display("FAIL watchdog: cycles=%0d expected below 20000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      load = 0; advance = 0; stop = 0;
    end
  endtask

  task automatic start(input logic [7:0] s, input logic [2:0] c, input logic o);
    @(negedge clk);
    load = 1; advance = 0; stop = 0; start_col = s; bl_code = c; ilv = o;
    @(negedge clk);
    load = 0;
  endtask

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      advance = 1; load = 0; stop = 0;
    end
    @(negedge clk);
    advance = 0;
  endtask

  initial begin
    tag = "R1"; idle(4);
    rst_n = 1; idle(2);
    tag = "R1 stray advance"; step(2); idle(1);

    tag = "R3 R6 seq8"; start(8'h35, 3'd3, 1'b0); step(9); idle(1);
    tag = "R2 R3 seq4"; start(8'hAE, 3'd2, 1'b0); step(4); idle(1);
    tag = "R3 seq2";    start(8'h13, 3'd1, 1'b0); step(2); idle(1);

    tag = "R4 R6 ilv8"; start(8'h5B, 3'd3, 1'b1); step(8); idle(1);
    tag = "R4 ilv4";    start(8'hC6, 3'd2, 1'b1); step(4); idle(1);

    tag = "R5 single";  start(8'h77, 3'd0, 1'b1); idle(2); step(1); idle(1);

    tag = "R11 hold";   start(8'h41, 3'd3, 1'b0); step(2); idle(5);
    tag = "R12 end";    step(6); idle(2);

    tag = "R7 full";    start(8'hFC, 3'd7, 1'b1); step(10); idle(1);
    tag = "R8 stop full";
    @(negedge clk); stop = 1; @(negedge clk); stop = 0; idle(1);

    tag = "R8 stop fixed"; start(8'h90, 3'd3, 1'b1); step(2);
    @(negedge clk); stop = 1; advance = 1; @(negedge clk); stop = 0; advance = 0; idle(1);

    tag = "R9 restart"; start(8'h10, 3'd3, 1'b0); step(3);
    start(8'h22, 3'd2, 1'b1); step(4); idle(1);
    tag = "R9 load over stop";
    start(8'h60, 3'd1, 1'b0);
    @(negedge clk); load = 1; stop = 1; advance = 1; start_col = 8'hE5; bl_code = 3'd2; ilv = 1'b0;
    @(negedge clk); load = 0; stop = 0; advance = 0; step(4); idle(1);

    tag = "R10 reserved idle"; start(8'h33, 3'd4, 1'b0); idle(2);
    tag = "R10 reserved busy"; start(8'h08, 3'd3, 1'b0); step(1);
    start(8'hF0, 3'd5, 1'b1); start(8'hF1, 3'd6, 1'b0); step(7); idle(2);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule